// File: doc/BRIEF.md
# 4b6b Framed Packet Receiver

This block sits behind a bit-clock recovery stage. On every recovered-bit strobe it receives the bit just decided together with a 12-bit history window. The newest bit sits in window bit 11 and older bits move toward bit 0. While idle, it looks for a fixed 12-bit start pattern in that window. Once the pattern is found, it collects groups of twelve bits. Each group is split into two 6-bit symbols, and each symbol is mapped back to a nibble through the DC-balanced 4b6b code.

The first byte of each frame gives the frame length in bytes, and that count includes the length byte itself. If this length is outside the range from 7 to `MAX_LEN`, the frame is dropped and a saturating reject counter is bumped. Otherwise every decoded byte, the length byte included, is presented on a one-cycle write strobe with its index. When the last byte has been written, the block raises a full flag. The flag holds until the consumer pulses a clear input, and the receiver does not start a new frame while it is set.

Top module: `frame_rx_4b6b`

## Requirements
- R1: After reset, `active`, `full` and `wr_en` are 0 and `bad_cnt` is 0.
- R2: While idle and not full, a bit strobe with `win` equal to `START` (default 12'hB38) sets `active` on the next cycle and clears the bit and byte counters.
- R3: While active, every twelfth bit strobe yields one decoded byte; the first group completes on the twelfth strobe after the start match.
- R4: A decoded byte takes its high nibble from `win[5:0]` and its low nibble from `win[11:6]`.
- R5: Symbols decode with the table 0x0D,0x0E,0x13,0x15,0x16,0x19,0x1A,0x1C,0x23,0x25,0x26,0x29,0x2A,0x2C,0x32,0x34 for nibbles 0 through F; any other symbol decodes as nibble 0.
- R6: When the first byte of a frame is below 7 or above `MAX_LEN` (default 67), the block leaves the active state, writes nothing, and increments `bad_cnt` by one.
- R7: Accepted bytes appear with `wr_en` high for one cycle, one cycle after the completing strobe, with `wr_idx` counting 0,1,2,... The length byte is written at index 0.
- R8: When the number of written bytes reaches the length byte, `active` falls and `full` rises on the same edge as the last write.
- R9: `full` stays set until `clr_full` is pulsed. While `full` is set, start patterns are ignored and `active` stays 0.
- R10: `bad_cnt` saturates at its all-ones value (width `BAD_W`) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | One-cycle strobe per recovered bit |
| win | input | 12 | Recent-bit window, newest bit in bit 11 |
| clr_full | input | 1 | One-cycle clear of the full flag |
| wr_en | output | 1 | Byte write strobe |
| wr_data | output | 8 | Decoded byte |
| wr_idx | output | IDX_W | Byte index within the frame |
| full | output | 1 | Complete frame held |
| active | output | 1 | Frame reception in progress |
| bad_cnt | output | BAD_W | Saturating count of rejected frames |

## Verification
The bench drives length bytes at both edges of the legal range: 6 and 68 must be rejected, while 7 and 67 must be accepted. An off-by-one bound would either store a bad frame or reject a good one. It sends a symbol that is not in the code table, where a design with a missing default would emit stale nibbles, and it uses asymmetric bytes that expose swapped nibble halves. It also sends a start pattern while the full flag is set, which a design that ignores the flag would accept. Finally, it pushes enough rejects into a narrow counter to show whether the counter wraps instead of saturating.

// File: rtl/frame_rx_4b6b.sv
module frame_rx_4b6b #(
  parameter logic [11:0] START   = 12'hB38,
  parameter int          MAX_LEN = 67,
  parameter int          BAD_W   = 16,
  localparam int         IDX_W   = $clog2(MAX_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic [11:0]      win,
  input  logic             clr_full,
  output logic             wr_en,
  output logic [7:0]       wr_data,
  output logic [IDX_W-1:0] wr_idx,
  output logic             full,
  output logic             active,
  output logic [BAD_W-1:0] bad_cnt
);

  function automatic logic [3:0] dec6(input logic [5:0] s);
    case (s)
      6'h0D: dec6 = 4'h0;  6'h0E: dec6 = 4'h1;
      6'h13: dec6 = 4'h2;  6'h15: dec6 = 4'h3;
      6'h16: dec6 = 4'h4;  6'h19: dec6 = 4'h5;
      6'h1A: dec6 = 4'h6;  6'h1C: dec6 = 4'h7;
      6'h23: dec6 = 4'h8;  6'h25: dec6 = 4'h9;
      6'h26: dec6 = 4'hA;  6'h29: dec6 = 4'hB;
      6'h2A: dec6 = 4'hC;  6'h2C: dec6 = 4'hD;
      6'h32: dec6 = 4'hE;  6'h34: dec6 = 4'hF;
      default: dec6 = 4'h0;
    endcase
  endfunction

  logic [3:0]       bcnt;
  logic [IDX_W-1:0] idx;
  logic [7:0]       len_q;

  wire [7:0] byte_w  = {dec6(win[5:0]), dec6(win[11:6])};
  wire       first   = (idx == '0);
  wire [7:0] len_w   = first ? byte_w : len_q;
  wire       len_bad = first && ((byte_w < 8'd7) || (32'(byte_w) > MAX_LEN));
  wire       last    = (32'(idx) + 1) >= 32'(len_w);
  wire       grp     = active && bit_vld && (bcnt == 4'd11);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bcnt    <= '0;
      idx     <= '0;
      len_q   <= '0;
      active  <= 1'b0;
      full    <= 1'b0;
      bad_cnt <= '0;
      wr_en   <= 1'b0;
      wr_data <= '0;
      wr_idx  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (clr_full) full <= 1'b0;
      if (bit_vld && !active) begin
        if (!full && win == START) begin
          active <= 1'b1;
          bcnt   <= '0;
          idx    <= '0;
        end
      end else if (bit_vld && !grp) begin
        bcnt <= bcnt + 4'd1;
      end else if (grp) begin
        bcnt <= '0;
        if (len_bad) begin
          active <= 1'b0;
          if (bad_cnt != '1) bad_cnt <= bad_cnt + 1'b1;
        end else begin
          wr_en   <= 1'b1;
          wr_data <= byte_w;
          wr_idx  <= idx;
          idx     <= idx + 1'b1;
          if (first) len_q <= byte_w;
          if (last) begin
            active <= 1'b0;
            full   <= 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/frame_rx_4b6b_chk.sv
module frame_rx_4b6b_chk #(
  parameter int MAX_LEN = 67,
  parameter int BAD_W   = 16,
  parameter int IDX_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             full,
  input logic             active,
  input logic [BAD_W-1:0] bad_cnt
);
  AST_WR_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> $past(active)); // R7
  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> (32'(wr_idx) < MAX_LEN)); // R7
  AST_FULL_NOT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) !(full && active)); // R8
  AST_FULL_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n) (full && !active) |=> !active); // R9
  AST_BAD_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (bad_cnt != $past(bad_cnt)) |-> (bad_cnt == $past(bad_cnt) + 1'b1)); // R6
  AST_BAD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (bad_cnt == '1) |=> (bad_cnt == '1)); // R10
endmodule

bind frame_rx_4b6b frame_rx_4b6b_chk #(.MAX_LEN(MAX_LEN), .BAD_W(BAD_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .full(full), .active(active), .bad_cnt(bad_cnt)
);

// File: tb/tb_frame_rx_4b6b.sv
`timescale 1ns/1ps
module tb_frame_rx_4b6b;
  localparam int MAXL = 67;
  localparam int BW   = 3;
  localparam logic [11:0] SP = 12'hB38;

  logic clk = 1'b0, rst_n = 1'b0, bit_vld = 1'b0, clr_full = 1'b0;
  logic [11:0] win = '0;
  logic wr_en, full, active;
  logic [7:0] wr_data;
  logic [6:0] wr_idx;
  logic [BW-1:0] bad_cnt;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  always #10 clk = ~clk;

  frame_rx_4b6b #(.START(SP), .MAX_LEN(MAXL), .BAD_W(BW)) dut (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .win(win), .clr_full(clr_full),
    .wr_en(wr_en), .wr_data(wr_data), .wr_idx(wr_idx), .full(full),
    .active(active), .bad_cnt(bad_cnt));

  function automatic logic [5:0] enc(input logic [3:0] n);
    logic [5:0] t[16] = '{6'h0D,6'h0E,6'h13,6'h15,6'h16,6'h19,6'h1A,6'h1C,
                          6'h23,6'h25,6'h26,6'h29,6'h2A,6'h2C,6'h32,6'h34};
    return t[n];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_vld = 1'b1;
    win = {b, win[11:1]};
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic send_raw(input logic [11:0] g);
    for (int i = 0; i < 12; i++) send_bit(g[i]);
  endtask

  task automatic send_start();
    send_raw(12'h000);
    send_raw(SP);
  endtask

  task automatic send_byte(input logic [7:0] b, input int idx, input bit expect_wr);
    if (expect_wr) exp_q.push_back({8'(idx), b});
    send_raw({enc(b[3:0]), enc(b[7:4])});
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_en) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected write", int'(wr_data), -1);
      end else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(wr_data == e[7:0], "R4/R5 data", int'(wr_data), int'(e[7:0]));
        check(int'(wr_idx) == int'(e[15:8]), "R7 index", int'(wr_idx), int'(e[15:8]));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #3000000;
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [7:0] fr[7];
    fr = '{8'd7, 8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h12, 8'hE9};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!active && !full && !wr_en && bad_cnt == 0, "R1 reset state",
          int'({active, full, wr_en}), 0);

    // R2: start match
    send_start();
    check(active, "R2 active after start", int'(active), 1);

    // R3: no write before twelfth strobe
    for (int i = 0; i < 11; i++) send_bit(fr[0][i < 6 ? 0 : 0]);
    check(exp_q.size() == 0 && active, "R3 no early byte", int'(active), 1);
    rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; win = '0; @(negedge clk);

    // R7/R8: legal 7-byte frame
    send_start();
    for (int i = 0; i < 7; i++) send_byte(fr[i], i, 1'b1);
    @(negedge clk);
    check(full && !active, "R8 full after last byte", int'({full, active}), 2);
    check(exp_q.size() == 0, "R7 all bytes written", exp_q.size(), 0);

    // R9: start ignored while full
    send_start();
    check(!active && full, "R9 start ignored when full", int'({full, active}), 2);
    @(negedge clk); clr_full = 1'b1; @(negedge clk); clr_full = 1'b0;
    check(!full, "R9 clear drops full", int'(full), 0);

    // R6: too short
    send_start();
    send_byte(8'd6, 0, 1'b0);
    @(negedge clk);
    check(!active && bad_cnt == 1, "R6 length 6 rejected", int'(bad_cnt), 1);
    // R6: too long
    send_start();
    send_byte(8'd68, 0, 1'b0);
    @(negedge clk);
    check(!active && bad_cnt == 2, "R6 length 68 rejected", int'(bad_cnt), 2);
    check(!full, "R6 no full on reject", int'(full), 0);

    // R5: unknown symbol in high half decodes as 0
    send_start();
    send_byte(8'd7, 0, 1'b1);
    exp_q.push_back({8'd1, 8'h05});
    send_raw({enc(4'h5), 6'h3F});
    for (int i = 2; i < 7; i++) send_byte(8'(i * 17), i, 1'b1);
    @(negedge clk);
    check(full && exp_q.size() == 0, "R5 unknown symbol frame", exp_q.size(), 0);
    @(negedge clk); clr_full = 1'b1; @(negedge clk); clr_full = 1'b0;

    // R8: maximum legal length
    send_start();
    send_byte(8'(MAXL), 0, 1'b1);
    for (int i = 1; i < MAXL; i++) send_byte(8'(i * 37 + 11), i, 1'b1);
    @(negedge clk);
    check(full && !active && exp_q.size() == 0, "R8 length 67 accepted",
          int'(full), 1);
    @(negedge clk); clr_full = 1'b1; @(negedge clk); clr_full = 1'b0;

    // R10: saturation
    for (int k = 3; k <= 9; k++) begin
      send_start();
      send_byte(8'd3, 0, 1'b0);
      @(negedge clk);
      check(int'(bad_cnt) == (k > 7 ? 7 : k), "R10 saturating reject count",
            int'(bad_cnt), (k > 7 ? 7 : k));
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule